// File: doc/BRIEF.md
# Right-Justified Serial Audio Receiver

This block takes a two-channel serial audio stream whose samples sit at the end of each half-frame and turns it into parallel left and right samples. It runs directly on the serial bit clock and samples serial data and the word clock on its rising edge. A high word clock marks the left half-frame and a low word clock marks the right half-frame. The least significant bit of each sample is the last bit before the word clock changes level.

The number of bit-clock periods in a half-frame depends on the bit-clock-to-frame ratio, so the number of padding bits ahead of each sample varies. The receiver does not count from the start of the half-frame. It shifts every bit into a register and, on each word-clock change, takes the most recent N bits as the sample for the channel that just ended. A width input selects 16-bit or 24-bit samples. In 16-bit mode the outputs are sign-extended to 24 bits. Once the right sample of a frame has been taken, a one-cycle strobe presents the left and right samples together as a pair.

Top module: `rj_audio_rx`

## Requirements
- R1: The sample taken at a word-clock change is made of the last N bits received before that change, most significant bit first. The final bit sampled while the old word-clock level was still present is the least significant bit.
- R2: Bits received while `lrclk`=1 update `left_out`, and bits received while `lrclk`=0 update `right_out`.
- R3: With `wide_mode`=1, N is 24 and the full 24-bit sample appears on the output.
- R4: With `wide_mode`=0, N is 16. The output carries the sample in bits 15:0, and bits 23:16 are copies of bit 15. Padding bits before the sample have no effect on the output.
- R5: Half-frames of 16, 24, 32, 64 or 128 bit-clock periods (32, 48, 64, 128 and 256 times the frame rate) are all received correctly, whatever padding comes before the sample.
- R6: `pair_valid` is high for exactly one cycle, and only after a low-to-high word-clock change ends a right half-frame. It rises on the first rising bit-clock edge at which the new high level is sampled. `left_out` and `right_out` are updated on that same edge.
- R7: Between word-clock changes, `left_out` and `right_out` hold their values.
- R8: While `rst_n`=0 on a rising clock edge, both outputs are cleared to zero and `pair_valid` is low. The half-frame that is in progress when reset is released is discarded. The first `pair_valid` comes only after a complete left half-frame and a complete right half-frame have both been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1 selects 24-bit samples, 0 selects 16-bit samples |
| lrclk | input | 1 | Word clock; 1 for the left half-frame, 0 for the right half-frame |
| sdata | input | 1 | Serial data, most significant bit first |
| left_out | output | 24 | Latest left sample, sign-extended in 16-bit mode |
| right_out | output | 24 | Latest right sample, sign-extended in 16-bit mode |
| pair_valid | output | 1 | One-cycle strobe that presents a new left/right pair |

## Verification
Every ratio from 32 to 256 times the frame rate is driven with alternating padding ahead of the sample. A receiver that counted from the start of the half-frame, or one off by a bit at the word-clock change, would shift the sample or mix padding into it. The sample values have the top or bottom bit set so that a wrong sign extension or a wrong bit order shows up in the output. The word clock stays high right after reset, so a receiver that took the half-frame interrupted by reset as valid would strobe a pair too early. Switching between the two widths checks that the bits above bit 15 do not leak in 16-bit mode.

// File: rtl/rjrx_pkg.sv
// Shared constants and types for the right-justified audio receiver.
package rjrx_pkg;
    localparam int RJ_MAX_W    = 24;
    localparam int RJ_NARROW_W = 16;

    // Channel that a half-frame belongs to, encoded as the word-clock level.
    typedef enum logic {
        CH_RIGHT = 1'b0,
        CH_LEFT  = 1'b1
    } chan_e;
endpackage

// File: rtl/rjrx_lr_track.sv
// Word-clock tracker. Registers the word clock and reports a level change
// relative to the previous sampled bit. Assumes the word clock is sampled
// on the same rising edge as the data. The first change after reset only
// arms the tracker, because the half-frame before it may be truncated.
module rjrx_lr_track
    import rjrx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lrclk,
    output logic  capture_en,
    output chan_e ended_ch
);
    logic lr_q;
    logic have_prev;
    logic armed;
    logic level_change;

    // A change is meaningful only once a previous level was captured out of reset.
    assign level_change = have_prev && (lrclk != lr_q);
    assign capture_en   = level_change && armed;
    assign ended_ch     = chan_e'(lr_q);

    // Track the previous word-clock level and arm on the first change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_q      <= 1'b0;
            have_prev <= 1'b0;
            armed     <= 1'b0;
        end else begin
            lr_q      <= lrclk;
            have_prev <= 1'b1;
            if (level_change) begin
                armed <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rjrx_shifter.sv
// Serial-in shift register. Keeps the most recent W data bits, newest in
// bit 0. It ignores frame boundaries, so padding simply falls off the top.
module rjrx_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdata,
    output logic [W-1:0] word
);
    // Shift one bit per bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else begin
            word <= {word[W-2:0], sdata};
        end
    end
endmodule

// File: rtl/rjrx_capture.sv
// Sample capture. On a qualified word-clock change, takes the low N bits of
// the shift word (N selected by wide_mode) into the register of the channel
// that just ended. Narrow samples are sign-extended. Raises a one-cycle pair
// strobe when a right sample lands after at least one left sample.
module rjrx_capture
    import rjrx_pkg::*;
#(
    parameter int MAX_W    = RJ_MAX_W,
    parameter int NARROW_W = RJ_NARROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_en,
    input  chan_e            ended_ch,
    input  logic             wide_mode,
    input  logic [MAX_W-1:0] shift_word,
    output logic [MAX_W-1:0] left_out,
    output logic [MAX_W-1:0] right_out,
    output logic             pair_valid
);
    localparam int EXT_W = MAX_W - NARROW_W;

    logic [MAX_W-1:0] sample_ext;
    logic             left_seen;

    // Select the sample width and sign-extend the narrow form.
    always_comb begin
        if (wide_mode) begin
            sample_ext = shift_word;
        end else begin
            sample_ext = {{EXT_W{shift_word[NARROW_W-1]}}, shift_word[NARROW_W-1:0]};
        end
    end

    // One holding register for each channel; index equals the channel code.
    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        logic [MAX_W-1:0] held;

        // Load this channel's register when its half-frame ends.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held <= '0;
            end else if (capture_en && (ended_ch == chan_e'(ch))) begin
                held <= sample_ext;
            end
        end
    end

    assign left_out  = g_ch[1].held;
    assign right_out = g_ch[0].held;

    // Pulse the pair strobe when a right sample completes a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_seen  <= 1'b0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= capture_en && (ended_ch == CH_RIGHT) && left_seen;
            if (capture_en && (ended_ch == CH_LEFT)) begin
                left_seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rj_audio_rx.sv
// Right-justified two-channel serial audio receiver. Runs on the bit clock.
// Assumes data and word clock are valid at the rising edge and that every
// half-frame holds at least as many bits as the selected sample width.
module rj_audio_rx
    import rjrx_pkg::*;
#(
    parameter int MAX_W    = RJ_MAX_W,
    parameter int NARROW_W = RJ_NARROW_W
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             wide_mode,
    input  logic             lrclk,
    input  logic             sdata,
    output logic [MAX_W-1:0] left_out,
    output logic [MAX_W-1:0] right_out,
    output logic             pair_valid
);
    logic             capture_en;
    chan_e            ended_ch;
    logic [MAX_W-1:0] shift_word;

    rjrx_lr_track u_track (
        .clk        (sclk),
        .rst_n      (rst_n),
        .lrclk      (lrclk),
        .capture_en (capture_en),
        .ended_ch   (ended_ch)
    );

    rjrx_shifter #(.W(MAX_W)) u_shift (
        .clk   (sclk),
        .rst_n (rst_n),
        .sdata (sdata),
        .word  (shift_word)
    );

    rjrx_capture #(.MAX_W(MAX_W), .NARROW_W(NARROW_W)) u_cap (
        .clk        (sclk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .ended_ch   (ended_ch),
        .wide_mode  (wide_mode),
        .shift_word (shift_word),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );
endmodule

// File: rtl/rjrx_checker.sv
// Port-level properties of the receiver, bound to every instance of the top.
module rjrx_checker #(
    parameter int MAX_W    = 24,
    parameter int NARROW_W = 16
) (
    input logic             sclk,
    input logic             rst_n,
    input logic             wide_mode,
    input logic             lrclk,
    input logic [MAX_W-1:0] left_out,
    input logic [MAX_W-1:0] right_out,
    input logic             pair_valid
);
    localparam int EXT_W = MAX_W - NARROW_W;

    p_strobe_once_r6: assert property (@(posedge sclk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    p_strobe_on_rise_r6: assert property (@(posedge sclk) disable iff (!rst_n)
        pair_valid |-> ($past(lrclk) && !$past(lrclk, 2)));

    p_hold_r7: assert property (@(posedge sclk) disable iff (!rst_n)
        ($past(rst_n) && ($past(lrclk) == $past(lrclk, 2)))
            |-> ($stable(left_out) && $stable(right_out)));

    p_left_sign_r4: assert property (@(posedge sclk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wide_mode) && !$stable(left_out))
            |-> (left_out[MAX_W-1:NARROW_W] == {EXT_W{left_out[NARROW_W-1]}}));

    p_right_sign_r4: assert property (@(posedge sclk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wide_mode) && !$stable(right_out))
            |-> (right_out[MAX_W-1:NARROW_W] == {EXT_W{right_out[NARROW_W-1]}}));

    p_reset_clear_r8: assert property (@(posedge sclk) disable iff (!rst_n)
        !$past(rst_n) |-> (left_out == '0 && right_out == '0 && !pair_valid));
endmodule

bind rj_audio_rx rjrx_checker #(.MAX_W(MAX_W), .NARROW_W(NARROW_W)) u_chk (
    .sclk       (sclk),
    .rst_n      (rst_n),
    .wide_mode  (wide_mode),
    .lrclk      (lrclk),
    .left_out   (left_out),
    .right_out  (right_out),
    .pair_valid (pair_valid)
);

// File: tb/tb_rj_audio_rx.sv
module tb_rj_audio_rx;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    // Vector layout: {wide, half-frame length (9 bits), left (24), right (24)}.
    localparam logic [57:0] VECS [NVEC] = '{
        {1'b1, 9'd24,  24'h800001, 24'h7FFFFE},
        {1'b1, 9'd32,  24'hA5C3F0, 24'h123456},
        {1'b1, 9'd128, 24'hFFFFFF, 24'h000001},
        {1'b0, 9'd16,  24'h008001, 24'h007FFF},
        {1'b0, 9'd24,  24'h001234, 24'h00FEDC},
        {1'b0, 9'd32,  24'h00C001, 24'h000003},
        {1'b0, 9'd64,  24'h00FFFF, 24'h008000},
        {1'b0, 9'd128, 24'h005A5A, 24'h00A5A5},
        {1'b1, 9'd64,  24'h7FFFFF, 24'h800000}
    };

    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b1;
    logic        lrclk = 1'b1;
    logic        sdata = 1'b0;
    logic [23:0] left_out;
    logic [23:0] right_out;
    logic        pair_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic        pend = 1'b0;
    logic        pend_valid;
    logic [23:0] exp_l;
    logic [23:0] exp_r;
    logic [23:0] hold_l;
    logic [23:0] hold_r;

    always #(CLK_PERIOD/2) sclk = ~sclk;

    rj_audio_rx dut (
        .sclk       (sclk),
        .rst_n      (rst_n),
        .wide_mode  (wide_mode),
        .lrclk      (lrclk),
        .sdata      (sdata),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] extend(input logic wide, input logic [23:0] s);
        return wide ? s : {{8{s[15]}}, s[15:0]};
    endfunction

    // Send one half-frame. Bit 0 sees the previous pair's strobe and checks it;
    // the mid-point checks that outputs hold; the mode is applied after bit 0.
    task automatic send_half(input logic lvl, input logic wide, input int half,
                             input logic [23:0] samp);
        int n;
        n = wide ? 24 : 16;
        for (int k = 0; k < half; k++) begin
            @(negedge sclk);
            lrclk = lvl;
            if (k == 1) wide_mode = wide;
            if (k >= half - n) sdata = samp[n - 1 - (k - (half - n))];
            else sdata = ~k[0];
            @(posedge sclk);
            #1;
            if (k == 0 && lvl && pend) begin
                // R6: strobe and both samples appear on the first edge of the high level
                check("R6 pair_valid at rise", {23'd0, pair_valid}, {23'd0, pend_valid});
                check("R1/R2 left sample", left_out, exp_l);
                check("R1/R2 right sample", right_out, exp_r);
                hold_l = exp_l;
                hold_r = exp_r;
            end
            if (k == 1 && lvl && pend) begin
                check("R6 strobe lasts one cycle", {23'd0, pair_valid}, 24'd0);
                pend = 1'b0;
            end
            if (k == half / 2 && lvl) begin
                // R7: outputs hold inside the left half-frame
                check("R7 left hold", left_out, hold_l);
                check("R7 right hold", right_out, hold_r);
            end
        end
    endtask

    initial begin
        // R8: reset clears the outputs and the strobe
        rst_n = 1'b0;
        repeat (4) @(posedge sclk);
        #1;
        check("R8 reset left", left_out, 24'd0);
        check("R8 reset right", right_out, 24'd0);
        check("R8 reset strobe", {23'd0, pair_valid}, 24'd0);
        hold_l = 24'd0;
        hold_r = 24'd0;
        @(negedge sclk);
        rst_n = 1'b1;

        // R8: the half-frame in progress at reset release is dropped, so no pair yet
        send_half(1'b1, 1'b1, 32, 24'hDEAD01);
        send_half(1'b0, 1'b1, 32, 24'h0BEEF0);
        pend = 1'b1;
        pend_valid = 1'b0;
        exp_l = 24'd0;
        exp_r = 24'h0BEEF0;

        // R1 R2 R3 R4 R5: table of widths, ratios and samples
        for (int v = 0; v < NVEC; v++) begin
            logic        w;
            int          h;
            logic [23:0] ls;
            logic [23:0] rs;
            w  = VECS[v][57];
            h  = int'(VECS[v][56:48]);
            ls = VECS[v][47:24];
            rs = VECS[v][23:0];
            send_half(1'b1, w, h, ls);
            send_half(1'b0, w, h, rs);
            pend = 1'b1;
            pend_valid = 1'b1;
            exp_l = extend(w, ls);
            exp_r = extend(w, rs);
        end
        // R4: the last 24-bit pair is followed by a 16-bit frame whose padding bits are set
        send_half(1'b1, 1'b0, 24, 24'h00FFFE);
        send_half(1'b0, 1'b0, 24, 24'h000101);
        pend = 1'b1;
        pend_valid = 1'b1;
        exp_l = 24'hFFFFFE;
        exp_r = 24'h000101;
        send_half(1'b1, 1'b0, 16, 24'h0);

        // R8: a reset in mid-frame clears the outputs again
        @(negedge sclk);
        rst_n = 1'b0;
        @(posedge sclk);
        #1;
        check("R8 mid-run reset left", left_out, 24'd0);
        check("R8 mid-run reset strobe", {23'd0, pair_valid}, 24'd0);
        @(negedge sclk);
        rst_n = 1'b1;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge sclk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule